// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt of a real-time-clock peripheral. It counts strobes from a 32768 Hz time base and raises a tick each time the selected period has gone by. A 4-bit rate code selects the period, and a separate enable gates the generator. Each tick sets a sticky periodic flag and asserts an interrupt request. Both stay set until a clear pulse arrives, which normally comes from a status read. The generator runs only while a 3-bit divider-control field holds a value in its running range.

The rate code may be reprogrammed while ticks are running. The count of strobes since the last tick is kept and measured against the new period, so the tick phase carries across the change. If the time already gone by meets or passes the new period, the tick fires at once. The next tick is therefore never later than one new period after the change.

All inputs are plain control pins sampled on the rising clock edge. No data stream flows through the block, so it has no handshake. Reset is synchronous and active high.

Top module: `periodic_rate_gen`

## Requirements
- R1: While reset is high at a clock edge, the strobe counter clears, and after that edge both per_flag and irq_req read 0.
- R2: With rate codes 3 to 15 and the generator running, a tick occurs on the 2^(code-1)-th strobe after the previous tick, or after the generator started. per_flag and irq_req read 1 from the clock edge that samples that strobe.
- R3: Rate code 1 gives a period of 128 strobes and rate code 2 gives a period of 256 strobes.
- R4: Rate code 0, or pie_en at 0, stops the generator and resets the strobe count to zero. While stopped, no tick occurs and the flags are not set. When the generator resumes, it counts a full period from zero.
- R5: The generator runs only while div_ctl is 0, 1 or 2. Any value from 3 to 7 stops it and resets the count in the same way as R4.
- R6: A tick sets per_flag and irq_req together. Both remain set until a clear is applied, and irq_req never rises unless pie_en was 1 in the cycle before.
- R7: A flag_clr pulse in a cycle with no tick makes both outputs read 0 after the next edge. If a tick falls in the same cycle as flag_clr, the tick wins and both outputs read 1.
- R8: A rate change while running keeps the strobe count gathered since the last tick. If that count already meets or passes the new period, a tick occurs in the cycle of the change without waiting for a strobe. Otherwise the next tick falls on the strobe that completes the new period.
- R9: In cycles where tb_stb is 0 and no overdue tick is pending, the strobe count holds, so the strobe rate and not the clock rate sets the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_stb | input | 1 | One-cycle strobe at 32768 Hz |
| rate_code | input | 4 | Period select; 0 stops the generator |
| div_ctl | input | 3 | Divider control; the generator runs only at 0 to 2 |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears both flags |
| per_flag | output | 1 | Sticky periodic flag |
| irq_req | output | 1 | Interrupt request, set together with per_flag |

## Verification
Two functions can land in the same cycle. A tick can meet a flag clear, and a rate change can meet a tick that is already overdue. The bench provokes the first case by pulsing flag_clr on every cycle under the shortest period, so some pulses land exactly on tick strobes. It provokes the second by dropping from a long period to a short one after hundreds of strobes. A behavioural reference model of counts and flags is advanced every clock, and per_flag and irq_req are compared against it after each edge. A lost tick, or a tick that fires one strobe late, shows up as a miscompare in that exact cycle.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned CODE_W      = 4;
  localparam int unsigned DIV_W       = 3;
  localparam int unsigned DIV_RUN_MAX = 2;
  localparam int unsigned ALIAS_ONE   = 8;
  localparam int unsigned ALIAS_TWO   = 9;
  localparam int unsigned CNT_W       = (1 << CODE_W) - 1;

  typedef struct packed {
    logic pf;
    logic irqf;
  } prg_flags_t;
endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode #(
  parameter int unsigned CODE_W      = prg_pkg::CODE_W,
  parameter int unsigned DIV_W       = prg_pkg::DIV_W,
  parameter int unsigned DIV_RUN_MAX = prg_pkg::DIV_RUN_MAX,
  parameter int unsigned ALIAS_ONE   = prg_pkg::ALIAS_ONE,
  parameter int unsigned ALIAS_TWO   = prg_pkg::ALIAS_TWO,
  parameter int unsigned CNT_W       = prg_pkg::CNT_W
) (
  input  logic [CODE_W-1:0] rate_code,
  input  logic [DIV_W-1:0]  div_ctl,
  input  logic              pie_en,
  output logic              run,
  output logic [CNT_W-1:0]  period
);
  localparam int unsigned NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] table_q [NCODES];

  // Period table: entries 1 and 2 alias to longer codes, the rest are powers of two.
  for (genvar c = 0; c < NCODES; c++) begin : g_tab
    if (c == 0) begin : g_zero
      assign table_q[c] = '0;
    end else if (c == 1) begin : g_a1
      assign table_q[c] = CNT_W'(1) << (ALIAS_ONE - 1);
    end else if (c == 2) begin : g_a2
      assign table_q[c] = CNT_W'(1) << (ALIAS_TWO - 1);
    end else begin : g_pow
      assign table_q[c] = CNT_W'(1) << (c - 1);
    end
  end

  logic div_ok;
  assign div_ok = (div_ctl <= DIV_W'(DIV_RUN_MAX));
  assign run    = pie_en && (rate_code != '0) && div_ok;
  assign period = table_q[rate_code];
endmodule

// File: rtl/prg_phase_counter.sv
module prg_phase_counter #(
  parameter int unsigned CNT_W = prg_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             strobe,
  input  logic [CNT_W-1:0] period,
  output logic             tick,
  output logic [CNT_W-1:0] elapsed
);
  logic [CNT_W:0] next_cnt;
  logic           overdue;
  logic           reach;

  assign next_cnt = {1'b0, elapsed} + 1'b1;
  assign overdue  = ({1'b0, elapsed} >= {1'b0, period});
  assign reach    = strobe && (next_cnt >= {1'b0, period});
  assign tick     = run && (overdue || reach);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) begin
      elapsed <= '0;
    end else if (strobe) begin
      elapsed <= next_cnt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/prg_flag_unit.sv
module prg_flag_unit
  import prg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       clr,
  output prg_flags_t flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (tick) begin
      flags.pf   <= 1'b1;
      flags.irqf <= 1'b1;
    end else if (clr) begin
      flags <= '0;
    end
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import prg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_stb,
  input  logic [CODE_W-1:0] rate_code,
  input  logic [DIV_W-1:0]  div_ctl,
  input  logic              pie_en,
  input  logic              flag_clr,
  output logic              per_flag,
  output logic              irq_req
);
  logic             run;
  logic [CNT_W-1:0] period;
  logic             tick;
  logic [CNT_W-1:0] elapsed;
  prg_flags_t       flags;

  prg_rate_decode u_dec (
    .rate_code (rate_code),
    .div_ctl   (div_ctl),
    .pie_en    (pie_en),
    .run       (run),
    .period    (period)
  );

  prg_phase_counter u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .strobe  (tb_stb),
    .period  (period),
    .tick    (tick),
    .elapsed (elapsed)
  );

  prg_flag_unit u_flg (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .clr   (flag_clr),
    .flags (flags)
  );

  assign per_flag = flags.pf;
  assign irq_req  = flags.irqf;
endmodule

// File: rtl/prg_checker.sv
module prg_checker
  import prg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tb_stb,
  input logic [CODE_W-1:0] rate_code,
  input logic [DIV_W-1:0]  div_ctl,
  input logic              pie_en,
  input logic              flag_clr,
  input logic              per_flag,
  input logic              irq_req,
  input logic              tick,
  input logic [CNT_W-1:0]  elapsed,
  input logic [CNT_W-1:0]  period
);
  logic live;
  assign live = pie_en && (rate_code != '0) && (div_ctl <= DIV_W'(DIV_RUN_MAX));

  assert_tick_needs_live_R4: assert property (@(posedge clk) disable iff (rst)
    tick |-> live);

  assert_div_stops_R5: assert property (@(posedge clk) disable iff (rst)
    (div_ctl > DIV_W'(DIV_RUN_MAX)) |-> !tick);

  assert_tick_sets_both_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> (per_flag && irq_req));

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (!irq_req ##1 irq_req) |-> $past(pie_en));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !tick) |=> (!per_flag && !irq_req));

  assert_no_double_tick_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (live && !tb_stb && (elapsed < period)) |=> $stable(elapsed));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!per_flag && !irq_req && (elapsed == '0)));
endmodule

bind periodic_rate_gen prg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tb_stb    (tb_stb),
  .rate_code (rate_code),
  .div_ctl   (div_ctl),
  .pie_en    (pie_en),
  .flag_clr  (flag_clr),
  .per_flag  (per_flag),
  .irq_req   (irq_req),
  .tick      (tick),
  .elapsed   (elapsed),
  .period    (period)
);

// File: tb/sim_periodic_rate_gen.sv
`timescale 1ns/1ps
module sim_periodic_rate_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_stb = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic [2:0] div_ctl = 3'd2;
  logic       pie_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       per_flag;
  logic       irq_req;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  int m_el = 0;
  bit m_pf = 1'b0;

  always #2 clk = ~clk;

  periodic_rate_gen u0 (
    .clk(clk), .rst(rst), .tb_stb(tb_stb), .rate_code(rate_code),
    .div_ctl(div_ctl), .pie_en(pie_en), .flag_clr(flag_clr),
    .per_flag(per_flag), .irq_req(irq_req)
  );

  function automatic int want_period(int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  // Reference model stepped once per clock with the inputs held across the edge.
  task automatic model_step();
    bit live;
    bit fire;
    int p;
    live = pie_en && (rate_code != 0) && (div_ctl <= 2);
    fire = 1'b0;
    if (rst) begin
      m_el = 0;
      m_pf = 1'b0;
      return;
    end
    if (!live) begin
      m_el = 0;
    end else begin
      p = want_period(int'(rate_code));
      if (m_el >= p) begin
        fire = 1'b1;
        m_el = 0;
      end else if (tb_stb) begin
        if (m_el + 1 >= p) begin
          fire = 1'b1;
          m_el = 0;
        end else begin
          m_el = m_el + 1;
        end
      end
    end
    if (fire) m_pf = 1'b1;
    else if (flag_clr) m_pf = 1'b0;
  endtask

  task automatic compare(string tag);
    vectors++;
    if (per_flag !== m_pf || irq_req !== m_pf) begin
      misses++;
      $display("FAIL %s t=%0t per_flag=%b irq_req=%b expected=%b",
               tag, $time, per_flag, irq_req, m_pf);
    end
  endtask

  task automatic run(int n, int stb_every, int clr_every, string tag);
    for (int i = 0; i < n; i++) begin
      tb_stb   = (i % stb_every) == 0;
      flag_clr = (clr_every != 0) && ((i % clr_every) == clr_every - 1);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
    end
    tb_stb   = 1'b0;
    flag_clr = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    run(3, 1, 0, "R1");
    rst = 1'b0;
    run(2, 1, 0, "R1");

    // R2: short periods, flags cleared now and then
    pie_en = 1'b1; rate_code = 4'd3;
    run(40, 1, 7, "R2");
    rate_code = 4'd7;
    run(200, 1, 50, "R2");

    // R9: sparse strobes stretch the period
    rate_code = 4'd4;
    run(90, 3, 11, "R9");

    // R3: aliased codes
    run(1, 1, 1, "R3");
    rate_code = 4'd1;
    run(300, 1, 100, "R3");
    rate_code = 4'd2;
    run(600, 1, 200, "R3");

    // R4: stop by code 0 and by enable, then resume from zero
    rate_code = 4'd5;
    run(20, 1, 0, "R4");
    rate_code = 4'd0;
    run(30, 1, 5, "R4");
    rate_code = 4'd5;
    run(40, 1, 13, "R4");
    pie_en = 1'b0;
    run(30, 1, 4, "R4");
    pie_en = 1'b1;
    run(40, 1, 9, "R4");

    // R5: divider field range
    div_ctl = 3'd3;
    run(40, 1, 6, "R5");
    div_ctl = 3'd7;
    run(40, 1, 6, "R5");
    div_ctl = 3'd0;
    run(40, 1, 10, "R5");
    div_ctl = 3'd2;

    // R6/R7: clear on every cycle, ticks land on some of them
    rate_code = 4'd3;
    run(60, 1, 1, "R7");
    run(30, 1, 0, "R6");

    // R8: long period then shorter rate mid-count (overdue fires at once)
    run(1, 1, 1, "R8");
    rate_code = 4'd10;
    run(300, 1, 0, "R8");
    run(1, 1, 1, "R8");
    rate_code = 4'd5;
    run(60, 1, 17, "R8");
    // R8: short to longer rate keeps phase
    rate_code = 4'd6;
    run(20, 1, 0, "R8");
    rate_code = 4'd9;
    run(400, 1, 37, "R8");

    // R2: longest period once
    rate_code = 4'd15;
    run(16400, 1, 8000, "R2");

    // R1: reset in the middle of a run
    rate_code = 4'd3;
    run(5, 1, 0, "R1");
    rst = 1'b1;
    run(2, 1, 0, "R1");
    rst = 1'b0;
    run(20, 1, 0, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired t=%0t actual=running expected=finished", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule